// File: doc/BRIEF.md
# External SRAM FIFO Controller

This block runs a byte-wide external static RAM as a first-in-first-out buffer. An acquisition front end hands it received bytes one at a time. A host, which runs at its own pace, drains the buffer through a small register window. The controller generates the RAM address, chip select and write enable. It also sets the direction of the data bus and holds two wrapping pointers and an occupancy count.

RAM cycles are time-sliced. A slot generator alternates write slots and read slots on every clock. A stored byte waits for the next write slot. A host fetch request is latched and served in the next read slot. Only one access can reach the single-port RAM in any cycle. The host sees a status register at address 0 and the data register at address 1. A write strobe to address 6 reinitialises the controller. With default parameters the RAM is 2048 x 8, using an 11-bit address.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: After reset the status reads 001 (empty) and the RAM is idle: chip select high, write enable high, data bus not driven.
- R2: Bytes come out of the data register in exactly the order they were presented on the acquisition input.
- R3: When the count reaches the RAM depth, a further incoming byte is discarded. The stored contents and the status 100 (full) remain unchanged until a read frees a location.
- R4: The status register (host address 0) carries the fill state in bits [2:0], one-hot: 001 empty, 010 holding data but not full, 100 full. All higher bits are zero.
- R5: Write enable goes low only in a write slot, together with chip select low and the controller driving the data bus. A read access (chip select low, write enable high) happens only in a read slot. Two consecutive cycles never both carry a write strobe.
- R6: A fetch request while the buffer is empty is dropped. No RAM access takes place, the data register keeps its value and the status stays empty.
- R7: A host write strobe to address 6, whatever the other inputs, empties the buffer and restarts both pointers. The next stored byte is the next one read.
- R8: The data register (host address 1) holds the last fetched byte until a later fetch replaces it.
- R9: Without a pending byte or fetch request, the RAM sees no access (chip select stays high).
- R10: Both pointers wrap modulo the RAM depth, so order is preserved across the end of the address space.
- R11: A host read strobe at address 1 requests one fetch. Reading address 0 consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-rate clock; one RAM slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_valid | input | 1 | One-cycle pulse: acq_data is to be stored |
| acq_data | input | DATA_W | Received byte from the front end |
| host_sel | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_rdata | output | DATA_W | Register selected by host_addr (0 status, 1 data) |
| sram_addr | output | ADDR_W | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_oe | output | 1 | High while the controller drives the RAM data bus |
| sram_dq_out | output | DATA_W | Byte driven onto the RAM data bus |
| sram_dq_in | input | DATA_W | Byte returned by the RAM |

## Verification
The bench builds the controller with ADDR_W = 3, which gives an eight-byte RAM, and DATA_W = 8. This small depth lets the bench reach a full buffer, an overflow attempt and pointer wrap-around in a few dozen transfers. The same logic at 11 address bits would need thousands. A behavioural RAM in the bench follows the strobes, so order and drop behaviour are observed only through the host register window.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        FILL_EMPTY  = 3'b001,
        FILL_NORMAL = 3'b010,
        FILL_FULL   = 3'b100
    } fill_state_e;

    localparam logic [2:0] REG_STATUS = 3'd0;
    localparam logic [2:0] REG_DATA   = 3'd1;
    localparam logic [2:0] REG_RESTART = 3'd6;

endpackage

// File: rtl/sfc_slot_gen.sv
module sfc_slot_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic write_slot
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = restart ? 1'b0 : ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    // phase 0 is the write slot, phase 1 the read slot
    assign write_slot = ~phase_q;
endmodule

// File: rtl/sfc_host_decode.sv
module sfc_host_decode #(
    parameter int DATA_W = 8
) (
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [2:0]        fill,
    input  logic [DATA_W-1:0] data_reg,
    output logic              fetch_req,
    output logic              restart_req,
    output logic [DATA_W-1:0] host_rdata
);
    import sfc_pkg::*;

    localparam int PAD_W = DATA_W - 3;

    always_comb begin
        fetch_req   = host_sel && host_rd && (host_addr == REG_DATA);
        restart_req = host_sel && host_wr && (host_addr == REG_RESTART);
        case (host_addr)
            REG_STATUS: host_rdata = {{PAD_W{1'b0}}, fill};
            REG_DATA:   host_rdata = data_reg;
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sram_fifo_ctrl.sv
module sram_fifo_ctrl #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_valid,
    input  logic [DATA_W-1:0] acq_data,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_dq_oe,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in
);
    import sfc_pkg::*;

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0]   CNT_MAX = DEPTH[ADDR_W:0];
    localparam logic [ADDR_W:0]   CNT_ONE = 1;
    localparam logic [ADDR_W-1:0] PTR_ONE = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [ADDR_W:0]   count;
        logic              wr_pend;
        logic [DATA_W-1:0] wr_byte;
        logic              rd_pend;
        logic [DATA_W-1:0] data_reg;
    } core_t;

    core_t       core_d, core_q;
    logic        write_slot;
    logic        fetch_req;
    logic        restart_req;
    logic        is_empty;
    logic        is_full;
    logic        do_write;
    logic        do_read;
    fill_state_e status;

    sfc_slot_gen u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart_req),
        .write_slot (write_slot)
    );

    sfc_host_decode #(.DATA_W(DATA_W)) u_host (
        .host_sel    (host_sel),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .fill        (status),
        .data_reg    (core_q.data_reg),
        .fetch_req   (fetch_req),
        .restart_req (restart_req),
        .host_rdata  (host_rdata)
    );

    always_comb begin
        is_empty = (core_q.count == '0);
        is_full  = (core_q.count == CNT_MAX);
        if (is_empty)     status = FILL_EMPTY;
        else if (is_full) status = FILL_FULL;
        else              status = FILL_NORMAL;

        do_write = write_slot && core_q.wr_pend && !is_full;
        do_read  = !write_slot && core_q.rd_pend && !is_empty;

        core_d = core_q;
        if (write_slot && core_q.wr_pend) begin
            core_d.wr_pend = 1'b0;
            if (do_write) begin
                core_d.wptr  = core_q.wptr + PTR_ONE;
                core_d.count = core_q.count + CNT_ONE;
            end
        end
        if (!write_slot && core_q.rd_pend) begin
            core_d.rd_pend = 1'b0;
            if (do_read) begin
                core_d.data_reg = sram_dq_in;
                core_d.rptr     = core_q.rptr + PTR_ONE;
                core_d.count    = core_q.count - CNT_ONE;
            end
        end
        if (acq_valid) begin
            core_d.wr_pend = 1'b1;
            core_d.wr_byte = acq_data;
        end
        if (fetch_req) core_d.rd_pend = 1'b1;
        if (restart_req) begin
            core_d.wptr    = '0;
            core_d.rptr    = '0;
            core_d.count   = '0;
            core_d.wr_pend = 1'b0;
            core_d.rd_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign sram_addr   = do_write ? core_q.wptr : core_q.rptr;
    assign sram_cs_n   = ~(do_write | do_read);
    assign sram_we_n   = ~do_write;
    assign sram_dq_oe  = do_write;
    assign sram_dq_out = core_q.wr_byte;
endmodule

// File: rtl/sfc_fifo_checker.sv
module sfc_fifo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sram_cs_n,
    input logic       sram_we_n,
    input logic       sram_dq_oe,
    input logic [2:0] status,
    input logic       write_slot
);
    a_r5_write_selects_and_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && sram_dq_oe));

    a_r5_drive_only_when_writing: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !sram_we_n);

    a_r5_write_in_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> write_slot);

    a_r5_read_in_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && sram_we_n) |-> !write_slot);

    a_r5_no_back_to_back_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);

    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'b100) |-> sram_we_n);

    a_r6_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'b001) |-> (sram_cs_n || !sram_we_n));

    a_r4_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) == 1);
endmodule

bind sram_fifo_ctrl sfc_fifo_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe),
    .status     (status),
    .write_slot (write_slot)
);

// File: tb/tb_sram_fifo_ctrl.sv
module tb_sram_fifo_ctrl;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_valid = 1'b0;
    logic [DW-1:0] acq_data = '0;
    logic          host_sel = 1'b0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [2:0]    host_addr = 3'd0;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;
    logic [DW-1:0] mem [0:DEPTH-1];

    int tests = 0;
    int fails = 0;
    int writes = 0;
    int accesses = 0;
    int back2back = 0;
    logic prev_we_low = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sram_fifo_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_data(acq_data),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_rdata(host_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_dq_oe(sram_dq_oe), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in)
    );

    // behavioural RAM
    always @(posedge clk) if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr] <= sram_dq_out;
    assign sram_dq_in = mem[sram_addr];

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_cs_n) accesses++;
            if (!sram_we_n) writes++;
            if (!sram_we_n && prev_we_low) back2back++;
            prev_we_low = !sram_we_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] b);
        @(negedge clk); acq_valid = 1'b1; acq_data = b;
        @(negedge clk); acq_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop(output logic [DW-1:0] b);
        @(negedge clk); host_sel = 1'b1; host_rd = 1'b1; host_addr = 3'd1;
        @(negedge clk); host_sel = 1'b0; host_rd = 1'b0;
        repeat (3) @(negedge clk);
        host_addr = 3'd1; #1; b = host_rdata;
    endtask

    task automatic read_status(output logic [DW-1:0] s);
        @(negedge clk); host_sel = 1'b1; host_rd = 1'b1; host_addr = 3'd0;
        #1; s = host_rdata;
        @(negedge clk); host_sel = 1'b0; host_rd = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); host_sel = 1'b1; host_wr = 1'b1; host_addr = 3'd6;
        @(negedge clk); host_sel = 1'b0; host_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] s;
        read_status(s);
        check("R1 reset status", s, 8'h01);
        check("R1 cs_n idle", sram_cs_n, 1);
        check("R1 we_n idle", sram_we_n, 1);
        check("R1 bus released", sram_dq_oe, 0);
    endtask

    task automatic t_order();
        logic [DW-1:0] s, b;
        int w0;
        w0 = writes;
        push(8'hA1); push(8'hB2); push(8'hC3);
        check("R5 one strobe per byte", writes - w0, 3);
        read_status(s);
        check("R4 normal status", s, 8'h02);
        read_status(s);
        check("R11 status read consumes nothing", s, 8'h02);
        pop(b); check("R2 first", b, 8'hA1);
        pop(b); check("R2 second", b, 8'hB2);
        pop(b); check("R2 third", b, 8'hC3);
        read_status(s);
        check("R4 empty again", s, 8'h01);
    endtask

    task automatic t_empty_read();
        logic [DW-1:0] s, b;
        int a0;
        a0 = accesses;
        pop(b);
        check("R6 no RAM access on empty fetch", accesses - a0, 0);
        check("R8 data register held", b, 8'hC3);
        read_status(s);
        check("R6 status still empty", s, 8'h01);
    endtask

    task automatic t_full();
        logic [DW-1:0] s, b;
        int w0;
        for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i));
        read_status(s);
        check("R3 full status", s, 8'h04);
        w0 = writes;
        push(8'hEE);
        check("R3 overflow byte not written", writes - w0, 0);
        read_status(s);
        check("R3 still full", s, 8'h04);
        for (int i = 0; i < DEPTH; i++) begin
            pop(b);
            check("R3 contents kept", b, 8'h10 + i);
        end
        read_status(s);
        check("R3 drained to empty", s, 8'h01);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] b;
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 5; i++) push(8'h40 + 8'(r * 8 + i));
            for (int i = 0; i < 5; i++) begin
                pop(b);
                check("R10 order across wrap", b, 8'h40 + r * 8 + i);
            end
        end
    endtask

    task automatic t_restart();
        logic [DW-1:0] s, b;
        push(8'h77); push(8'h88);
        restart();
        read_status(s);
        check("R7 restart empties", s, 8'h01);
        push(8'h5A);
        pop(b);
        check("R7 fresh byte first", b, 8'h5A);
    endtask

    task automatic t_idle();
        int a0;
        a0 = accesses;
        repeat (20) @(negedge clk);
        check("R9 idle RAM untouched", accesses - a0, 0);
        check("R5 no back-to-back write strobes", back2back, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_read();
        t_full();
        t_wrap();
        t_restart();
        t_idle();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule